// File: doc/BRIEF.md
# Half-Bridge Triangle Oscillator with Dead Time and Period Sweep

This block is a clocked digital oscillator that drives the two gate commands of a half-bridge: a low-side command and a high-side command. An up/down triangle counter sets the timing. The low side conducts in the rising half of the triangle and the high side in the falling half. Each conduction window is shortened at its start by a programmable dead-time count, so the two commands are never active together.

The switching period is set by a period word in clock cycles. After `run_i` rises, the block runs at the short preheat period, which is the highest frequency. A one-cycle pulse on `sweep_i` starts a linear shift. On each triangle cycle the period grows by `step_i` until it reaches the long run period, which is the lowest frequency. From then on, a signed correction term is added to the run period and the sum is clamped between the two limits. An outside regulation loop can use this term to trim the frequency. A new period takes effect only at a triangle valley. Dropping `run_i` stops the oscillator and forces both commands low.

Top module: `hb_dt_osc`

## Requirements
- R1: While `rst` is high, `lvg_o`, `hvg_o` and `dt_err_o` are 0 and `phase_o` is 0.
- R2: With a constant period word P (P >= 4), consecutive rising edges of `lvg_o` are exactly 2*floor(P/2) cycles apart.
- R3: With half-period H = floor(P/2) and dead count D, where 2*D < H, `lvg_o` and `hvg_o` are each high for H-D consecutive cycles in every period.
- R4: Between the end of the `lvg_o` pulse and the start of the `hvg_o` pulse there are exactly D cycles with both outputs low. The same gap of D cycles separates the end of `hvg_o` from the next `lvg_o`.
- R5: `lvg_o` and `hvg_o` are never high in the same cycle.
- R6: One cycle after `run_i` is sampled low, `lvg_o` and `hvg_o` are 0 and `phase_o` is 0. They stay so while `run_i` is low.
- R7: When 2*D >= H, `dt_err_o` is 1 and both outputs stay low. The case 2*D = H-2 runs normally.
- R8: A `sweep_i` pulse during preheat makes the period move from `per_pre_i` to `per_run_i` in increments of `step_i`, one per triangle cycle. The period never decreases along the way, and it settles at `per_run_i`.
- R9: After the sweep completes, the period is `per_run_i + corr_i`, with `corr_i` read as two's complement and the result clamped to the range [`per_pre_i`, `per_run_i`].
- R10: Before the sweep completes, `corr_i` has no effect on the period.
- R11: The period in use changes only at a triangle valley. Every measured rising-edge interval therefore equals 2*floor(P/2) for one whole period word P, never a mix of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | 1 = oscillate, 0 = stop with both gates low |
| sweep_i | input | 1 | One-cycle pulse that starts the preheat-to-run shift |
| per_pre_i | input | PW | Preheat (shortest) period in cycles |
| per_run_i | input | PW | Run (longest) period in cycles |
| step_i | input | PW | Period increment per triangle cycle during the shift; must be nonzero |
| dead_i | input | DW | Dead-time count in cycles |
| corr_i | input | PW | Signed period correction, applied after the shift |
| lvg_o | output | 1 | Low-side gate command |
| hvg_o | output | 1 | High-side gate command |
| phase_o | output | PW | Triangle counter value |
| dt_err_o | output | 1 | Dead time too long for the current half-period |

## Verification
The hardest state to reach from the ports is the post-sweep run phase with a live correction. The bench only gets there by running preheat, pulsing `sweep_i`, and waiting until the measured intervals stop growing. The same pass applies a positive correction during preheat, where it must be ignored. Once the period has settled at the run value, the bench drives a negative correction, a clamped-high correction and a clamped-low correction. It measures whole periods edge to edge, so any runt interval at a change would show up as a value outside the allowed set.

// File: rtl/hbo_pkg.sv
package hbo_pkg;
  typedef enum logic [1:0] {ST_STOP, ST_PRE, ST_SHIFT, ST_BURN} hbo_state_e;
endpackage

// File: rtl/hbo_period.sv
module hbo_period
  import hbo_pkg::*;
#(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          sweep_i,
  input  logic          valley_i,
  input  logic [PW-1:0] per_pre_i,
  input  logic [PW-1:0] per_run_i,
  input  logic [PW-1:0] step_i,
  input  logic [PW-1:0] corr_i,
  output logic [PW-1:0] half_o
);
  localparam int SW = PW + 2;

  hbo_state_e     st_q;
  logic [PW-1:0]  base_q;
  logic [PW:0]    nb;
  logic signed [SW-1:0] sum, lo, hi;
  logic [PW-1:0]  tgt;

  assign nb  = {1'b0, base_q} + {1'b0, step_i};
  assign lo  = $signed({2'b00, per_pre_i});
  assign hi  = $signed({2'b00, per_run_i});
  assign sum = $signed({2'b00, base_q}) + $signed({{2{corr_i[PW-1]}}, corr_i});

  always_comb begin
    if (st_q == ST_STOP)      tgt = per_pre_i;
    else if (st_q != ST_BURN) tgt = base_q;
    else if (sum < lo)        tgt = per_pre_i;
    else if (sum > hi)        tgt = per_run_i;
    else                      tgt = sum[PW-1:0];
  end
  assign half_o = tgt >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_STOP;
      base_q <= '0;
    end else if (!run_i) begin
      st_q   <= ST_STOP;
      base_q <= per_pre_i;
    end else begin
      case (st_q)
        ST_STOP:  st_q <= ST_PRE;
        ST_PRE:   if (sweep_i) st_q <= ST_SHIFT;
        ST_SHIFT: if (valley_i) begin
          if (nb >= {1'b0, per_run_i}) begin
            base_q <= per_run_i;
            st_q   <= ST_BURN;
          end else begin
            base_q <= nb[PW-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  // R8
  sweep_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SHIFT && valley_i && run_i) |=> base_q >= $past(base_q));
endmodule

// File: rtl/hbo_tri.sv
module hbo_tri #(
  parameter int PW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic [PW-1:0] half_i,
  input  logic [DW-1:0] dead_i,
  output logic          valley_o,
  output logic          lvg_o,
  output logic          hvg_o,
  output logic          err_o,
  output logic [PW-1:0] phase_o
);
  localparam int XW = PW + 1;

  logic          run_q, dir_q, active, err_c, lvg_n, hvg_n;
  logic [PW-1:0] k_q, half_q;

  assign active   = run_i & run_q;
  assign valley_o = active & dir_q & (k_q == '0);
  assign err_c    = XW'({dead_i, 1'b0}) >= XW'(half_q);
  assign lvg_n    = active & ~dir_q & ~err_c & (XW'(k_q) >= XW'(dead_i));
  assign hvg_n    = active &  dir_q & ~err_c & ((XW'(k_q) + XW'(dead_i)) < XW'(half_q));
  assign phase_o  = k_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; dir_q <= 1'b0; k_q <= '0; half_q <= '0;
      lvg_o <= 1'b0; hvg_o <= 1'b0; err_o <= 1'b0;
    end else begin
      run_q <= run_i;
      err_o <= err_c;
      lvg_o <= lvg_n;
      hvg_o <= hvg_n;
      if (!active) begin
        k_q <= '0; dir_q <= 1'b0; half_q <= half_i;
      end else if (!dir_q) begin
        if (k_q == half_q - 1'b1) dir_q <= 1'b1;
        else                      k_q <= k_q + 1'b1;
      end else begin
        if (k_q == '0) begin
          dir_q <= 1'b0; half_q <= half_i;
        end else begin
          k_q <= k_q - 1'b1;
        end
      end
    end
  end

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst) !(lvg_o && hvg_o));
  // R6
  stop_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (!lvg_o && !hvg_o && phase_o == '0));
  // R11
  half_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !valley_o) |=> $stable(half_q));
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (active && half_q != '0) |-> k_q < half_q);
endmodule

// File: rtl/hb_dt_osc.sv
module hb_dt_osc #(
  parameter int PW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          sweep_i,
  input  logic [PW-1:0] per_pre_i,
  input  logic [PW-1:0] per_run_i,
  input  logic [PW-1:0] step_i,
  input  logic [DW-1:0] dead_i,
  input  logic [PW-1:0] corr_i,
  output logic          lvg_o,
  output logic          hvg_o,
  output logic [PW-1:0] phase_o,
  output logic          dt_err_o
);
  logic          valley;
  logic [PW-1:0] half;

  hbo_period #(.PW(PW)) u_period (
    .clk, .rst, .run_i, .sweep_i, .valley_i(valley),
    .per_pre_i, .per_run_i, .step_i, .corr_i, .half_o(half)
  );

  hbo_tri #(.PW(PW), .DW(DW)) u_tri (
    .clk, .rst, .run_i, .half_i(half), .dead_i, .valley_o(valley),
    .lvg_o, .hvg_o, .err_o(dt_err_o), .phase_o
  );

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    dt_err_o |=> (!lvg_o && !hvg_o) || !$stable(dead_i) || !$stable(per_pre_i));
endmodule

// File: tb/hb_dt_osc_tb.sv
module hb_dt_osc_tb;
  localparam int PW = 12;
  localparam int DW = 8;
  // {period word, dead, expected interval, expected width}
  localparam int NV = 6;
  localparam int VEC [NV][4] = '{
    '{20, 3, 20, 7}, '{16, 0, 16, 8}, '{40, 5, 40, 15},
    '{11, 2, 10, 3}, '{20, 4, 20, 6}, '{8, 1, 8, 3}};

  logic clk = 0, rst = 1, run = 0, sweep = 0;
  logic [PW-1:0] pre = 20, runp = 20, step = 4, corr = 0;
  logic [DW-1:0] dead = 2;
  logic lvg, hvg, err;
  logic [PW-1:0] phase;
  int checks = 0, fails = 0, overlaps = 0;

  always #4 clk = ~clk;

  hb_dt_osc #(.PW(PW), .DW(DW)) u_dut (
    .clk, .rst, .run_i(run), .sweep_i(sweep), .per_pre_i(pre), .per_run_i(runp),
    .step_i(step), .dead_i(dead), .corr_i(corr),
    .lvg_o(lvg), .hvg_o(hvg), .phase_o(phase), .dt_err_o(err));

  always @(negedge clk) if (!rst && lvg && hvg) overlaps++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic meas(output int per, output int wl, output int wh, output int gap);
    bit fell = 0, hv = 0, lp;
    per = 0; wl = 0; wh = 0; gap = 0;
    for (int i = 0; i < 3000 && lvg; i++) @(negedge clk);
    for (int i = 0; i < 3000 && !lvg; i++) @(negedge clk);
    lp = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      if (lvg) wl++;
      if (hvg) begin wh++; hv = 1; end
      if (!lvg && lp) fell = 1;
      if (fell && !hv && !lvg && !hvg) gap++;
      lp = lvg;
      @(negedge clk);
      per++;
      if (lvg && !lp) break;
    end
  endtask

  task automatic restart();
    run = 0;
    repeat (3) @(negedge clk);
    run = 1;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int p, wl, wh, g, prev, mid;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 lvg", lvg, 0); chk("R1 hvg", hvg, 0);
    chk("R1 err", err, 0); chk("R1 phase", phase, 0);
    rst = 0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      pre = VEC[v][0]; runp = VEC[v][0]; dead = VEC[v][1];
      restart();
      meas(p, wl, wh, g);
      meas(p, wl, wh, g);
      chk("R2 period", p, VEC[v][2]);
      chk("R3 low width", wl, VEC[v][3]);
      chk("R3 high width", wh, VEC[v][3]);
      chk("R4 dead gap", g, VEC[v][1]);
    end

    // R6 stop
    run = 0;
    @(negedge clk);
    chk("R6 lvg", lvg, 0); chk("R6 hvg", hvg, 0); chk("R6 phase", phase, 0);
    wl = 0;
    repeat (30) begin @(negedge clk); if (lvg || hvg) wl++; end
    chk("R6 hold low", wl, 0);

    // R7 dead too long: H=10, D=5
    pre = 20; runp = 20; dead = 5;
    restart();
    wl = 0;
    repeat (10) @(negedge clk);
    repeat (60) begin @(negedge clk); if (lvg || hvg) wl++; end
    chk("R7 err flag", err, 1);
    chk("R7 outputs low", wl, 0);

    // R10 correction ignored in preheat; R8 sweep
    pre = 20; runp = 40; step = 4; dead = 2; corr = 10;
    restart();
    meas(p, wl, wh, g); meas(p, wl, wh, g);
    chk("R10 preheat period", p, 20);
    chk("R7 no err at boundary", err, 0);
    sweep = 1; @(negedge clk); sweep = 0;
    prev = 20; mid = 0; wl = 0;
    for (int i = 0; i < 10; i++) begin
      meas(p, wh, g, g);
      if (p < prev || p > 40 || (p % 4) != 0) wl++;
      if (p > 20 && p < 40) mid = 1;
      prev = p;
    end
    chk("R8 monotone steps", wl, 0);
    chk("R8 intermediate seen", mid, 1);
    chk("R8 final period", p, 40);
    // R9 positive correction clamps to run period
    meas(p, wl, wh, g);
    chk("R9 clamp high", p, 40);
    // R11 change mid-cycle: every interval 40 or 32
    repeat (7) @(negedge clk);
    corr = 12'hFF8;
    wl = 0;
    for (int i = 0; i < 4; i++) begin
      meas(p, wh, g, g);
      if (p != 40 && p != 32) wl++;
    end
    chk("R11 no runt", wl, 0);
    chk("R9 corrected period", p, 32);
    corr = 12'hF9C;
    meas(p, wl, wh, g); meas(p, wl, wh, g); meas(p, wl, wh, g);
    chk("R9 clamp low", p, 20);

    chk("R5 overlap cycles", overlaps, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule